// File: doc/BRIEF.md
# Compare-Value Deadline Timer Channel

This block is one timer channel for a single core. It watches a free-running 64-bit up-counter that arrives as an input. When the counter reaches a deadline held in a compare register, it raises a level interrupt. Software sets the deadline in one of two ways. It can write an absolute 64-bit compare value. It can also write a signed 32-bit offset, which the block adds to the live count at the moment of the write.

A deadline that is already behind the counter fires at once. The block does not wait for the counter to wrap. The comparison is plain unsigned 64-bit. A control register holds an enable bit and a mask bit, plus a read-only status bit that shows whether the deadline has been reached. Reads are combinational from the current state and the live counter. Writes land on the next rising clock edge.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the control register reads 0, the compare register reads 0, and `irq_o` is low.
- R2: Register selects are 0 for control, 1 for absolute compare, 2 for relative offset, and 3 for none. Writing select 1 loads `wr_data` into the compare register, and reading select 1 returns it from the next cycle. A write to select 3 changes nothing, and a read of select 3 returns 0.
- R3: Writing select 2 loads compare with the counter value at that edge plus the sign-extended low 32 bits of `wr_data`. Bits 63:32 of `wr_data` are ignored.
- R4: Reading select 2 returns (compare − counter), truncated to its low 32 bits and sign-extended to 64 bits.
- R5: Control bit 2 (status) reads 1 exactly when bit 0 (enable) is 1 and counter >= compare. Bit 1 (mask) has no effect on it.
- R6: `irq_o` is a level equal to enable AND NOT mask AND status. Setting the mask bit holds it low.
- R7: With the channel enabled and unmasked, a compare value at or below the counter raises `irq_o` as soon as that value is in place.
- R8: Writing 0 to control bit 0 drops both status and `irq_o` from the next cycle.
- R9: The counter and compare values are compared as unsigned numbers. A counter with bit 63 set is above a compare value with bit 63 clear.
- R10: A control write uses only bits 1:0. The status bit and all higher bits of the written value are ignored.
- R11: Writing a relative offset of 0 and then setting enable raises `irq_o` on the cycle after the enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_i | input | 64 | Free-running system counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 64 | Read data, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Every write lands on the first rising edge after the strobe. No register sits between the stored state and the outputs, so status, the interrupt and every read value are settled by the following falling edge. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then samples `rd_data` and `irq_o` one nanosecond after the next falling edge, while the counter is held steady. Checks that change only the counter, such as a deadline being reached or a relative read going negative, have no write in flight. They are sampled the same way, one edge after the new counter value is applied.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CMP  = 2'd1,
      SEL_REL  = 2'd2,
      SEL_NONE = 2'd3
   } tmr_sel_e;

   localparam int unsigned BIT_EN   = 0;
   localparam int unsigned BIT_MASK = 1;
   localparam int unsigned BIT_STAT = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned REL_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             en_q,
   output logic             mask_q,
   output logic [CNT_W-1:0] cmp_q
);
   localparam int unsigned EXT_W = CNT_W - REL_W;

   logic [CNT_W-1:0] rel_ext;
   logic [CNT_W-1:0] rel_target;

   assign rel_ext    = {{EXT_W{wr_data[REL_W-1]}}, wr_data[REL_W-1:0]};
   assign rel_target = count_i + rel_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= 1'b0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         unique case (tmr_sel_e'(wr_sel))
            SEL_CTRL: begin
               en_q   <= wr_data[BIT_EN];
               mask_q <= wr_data[BIT_MASK];
            end
            SEL_CMP:  cmp_q <= wr_data;
            SEL_REL:  cmp_q <= rel_target;
            default:  ;
         endcase
      end
   end

   AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CMP) |=> cmp_q == $past(wr_data)); // R2

   AST_REL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_REL) |=>
      cmp_q == $past(count_i) + {{EXT_W{$past(wr_data[REL_W-1])}}, $past(wr_data[REL_W-1:0])}); // R3

   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == SEL_CMP || wr_sel == SEL_REL)) |=> $stable(cmp_q)); // R2
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
   parameter int unsigned CNT_W = 64
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic             en_q,
   output logic             stat_o
);
   logic reached;

   assign reached = (count_i >= cmp_q);
   assign stat_o  = en_q & reached;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned REL_W = 32
) (
   input  logic [1:0]       rd_sel,
   input  logic             en_q,
   input  logic             mask_q,
   input  logic             stat,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] rd_data
);
   localparam int unsigned EXT_W = CNT_W - REL_W;

   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] remain_ext;
   logic [CNT_W-1:0] ctrl_word;

   assign remain     = cmp_q - count_i;
   assign remain_ext = {{EXT_W{remain[REL_W-1]}}, remain[REL_W-1:0]};

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[BIT_EN]   = en_q;
      ctrl_word[BIT_MASK] = mask_q;
      ctrl_word[BIT_STAT] = stat;
   end

   always_comb begin
      unique case (tmr_sel_e'(rd_sel))
         SEL_CTRL: rd_data = ctrl_word;
         SEL_CMP:  rd_data = cmp_q;
         SEL_REL:  rd_data = remain_ext;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned REL_W   = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq_o
);
   if (REL_W < 2 || REL_W >= CNT_W) begin : g_bad_rel
      $error("REL_W must lie between 2 and CNT_W-1");
   end
   if (CNT_W <= BIT_STAT) begin : g_bad_cnt
      $error("CNT_W too narrow for the control word");
   end

   logic             en_q;
   logic             mask_q;
   logic [CNT_W-1:0] cmp_q;
   logic             stat;
   logic             irq_raw;

   tmr_regs #(.CNT_W(CNT_W), .REL_W(REL_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (count_i),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .en_q    (en_q),
      .mask_q  (mask_q),
      .cmp_q   (cmp_q)
   );

   tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
      .count_i (count_i),
      .cmp_q   (cmp_q),
      .en_q    (en_q),
      .stat_o  (stat)
   );

   tmr_rdmux #(.CNT_W(CNT_W), .REL_W(REL_W)) u_rd (
      .rd_sel  (rd_sel),
      .en_q    (en_q),
      .mask_q  (mask_q),
      .stat    (stat),
      .cmp_q   (cmp_q),
      .count_i (count_i),
      .rd_data (rd_data)
   );

   assign irq_raw = stat & ~mask_q;

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_raw;

      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q |-> !irq_o); // R6

      AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q |-> !irq_o); // R8

      AST_PAST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q && !mask_q && count_i >= cmp_q) |-> irq_o); // R7

      AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == SEL_CTRL && !wr_data[BIT_EN]) |=> !irq_o); // R8
   end
endmodule

// File: tb/sim_cmp_timer_chan.sv
`timescale 1ns/1ps
module sim_cmp_timer_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] count_i = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [63:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [63:0] rd_data;
   logic        irq_o;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cmp_timer_chan u0 (
      .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   typedef struct packed {
      logic [63:0] cnt;
      logic        wr;
      logic [1:0]  wsel;
      logic [63:0] wdata;
      logic [1:0]  rsel;
      logic [63:0] exp_rd;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{64'd100, 1'b1, 2'd0, 64'd1, 2'd0, 64'd5, 1'b1, 8'd7},                     // R7 past deadline
      '{64'd100, 1'b1, 2'd1, 64'd200, 2'd1, 64'd200, 1'b0, 8'd2},                 // R2 absolute
      '{64'd100, 1'b0, 2'd0, 64'd0, 2'd0, 64'd1, 1'b0, 8'd5},                     // R5 not reached
      '{64'd200, 1'b0, 2'd0, 64'd0, 2'd0, 64'd5, 1'b1, 8'd5},                     // R5 equality
      '{64'd200, 1'b1, 2'd0, 64'd3, 2'd0, 64'd7, 1'b0, 8'd6},                     // R6 masked
      '{64'd200, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFF6, 2'd1, 64'd190, 1'b0, 8'd3}, // R3 negative
      '{64'd200, 1'b1, 2'd2, 64'hAAAA_AAAA_0000_0032, 2'd2, 64'd50, 1'b0, 8'd3},  // R3 high bits
      '{64'd300, 1'b0, 2'd0, 64'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFCE, 1'b0, 8'd4},   // R4 negative
      '{64'd300, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFC, 2'd0, 64'd0, 1'b0, 8'd10},  // R10 R8
      '{64'd300, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFF9, 2'd0, 64'd5, 1'b1, 8'd10},  // R10
      '{64'h8000_0000_0000_0000, 1'b1, 2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 2'd0, 64'd5, 1'b1, 8'd9}, // R9
      '{64'h10, 1'b1, 2'd1, 64'hFFFF_FFFF_FFFF_FFF0, 2'd0, 64'd1, 1'b0, 8'd9},    // R9
      '{64'h10, 1'b1, 2'd3, 64'd0, 2'd3, 64'd0, 1'b0, 8'd2},                      // R2 select 3
      '{64'h10, 1'b0, 2'd0, 64'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 8'd2},    // R2 unchanged
      '{64'h10, 1'b1, 2'd0, 64'd0, 2'd0, 64'd0, 1'b0, 8'd8},                      // R8 disable
      '{64'd500, 1'b1, 2'd2, 64'd0, 2'd2, 64'd0, 1'b0, 8'd11},                    // R11 offset 0
      '{64'd500, 1'b1, 2'd0, 64'd1, 2'd0, 64'd5, 1'b1, 8'd11}                     // R11 enable
   };

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input int req, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic [63:0] cnt, input logic wr, input logic [1:0] ws,
                       input logic [63:0] wd, input logic [1:0] rs);
      @(negedge clk);
      count_i = cnt; wr_en = wr; wr_sel = ws; wr_data = wd;
      @(negedge clk);
      wr_en = 1'b0; rd_sel = rs;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      count_i = 64'd50;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step(64'd50, 1'b0, 2'd0, 64'd0, 2'd0);
      chk(rd_data, 64'd0, 1, "ctrl after reset");
      chk({63'd0, irq_o}, 64'd0, 1, "irq after reset");
      rd_sel = 2'd1; #1;
      chk(rd_data, 64'd0, 1, "compare after reset");

      for (int i = 0; i < NV; i++) begin
         step(VECS[i].cnt, VECS[i].wr, VECS[i].wsel, VECS[i].wdata, VECS[i].rsel);
         chk(rd_data, VECS[i].exp_rd, int'(VECS[i].req), $sformatf("vector %0d read", i));
         chk({63'd0, irq_o}, {63'd0, VECS[i].exp_irq}, int'(VECS[i].req), $sformatf("vector %0d irq", i));
      end

      // R6 level holds while counter keeps advancing past the deadline
      for (int k = 1; k <= 3; k++) begin
         step(64'd500 + 64'(k * 1000), 1'b0, 2'd0, 64'd0, 2'd0);
         chk({63'd0, irq_o}, 64'd1, 6, "irq level held");
      end

      // R1 reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      step(64'd700, 1'b0, 2'd0, 64'd0, 2'd0);
      chk(rd_data, 64'd0, 1, "ctrl after second reset");
      chk({63'd0, irq_o}, 64'd0, 1, "irq after second reset");
      rd_sel = 2'd1; #1;
      chk(rd_data, 64'd0, 1, "compare after second reset");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule